// File: doc/BRIEF.md
# Synchronizable Switching Clock Generator

This block produces the start-of-cycle strobe for a flyback pulse-width modulator. It runs from a fixed system clock. It either free-runs at one of two internal rates or follows an external synchronization signal that has already been digitised.

Without a usable sync signal, the rate depends on the operating mode. Startup and standby use the slow rate. Normal mode uses the fast rate, but only while the feedback current stays above its normal-mode threshold. A rate change waits for the current switching cycle to finish, so no shortened cycle is ever emitted.

The block measures the time between rising edges of the sync input. Once two periods in a row fall inside the accepted frequency window, it locks. While locked, it issues one strobe per sync edge, placed one twentieth of the measured period after that edge. It returns to the internal rate when the sync edges stop arriving or arrive out of the window.

Top module: `swclk_gen`

## Requirements
- R1: While reset is asserted and at its release, `cyc_start_o` and `locked_o` are 0 and `period_o` is 0.
- R2: Unlocked, the block uses the slow interval of 500 clocks (10 MHz clock, 20 kHz) when `mode_i` is not 2'b10, or when `mode_i` is 2'b10 with `fb_high_i` low. Mode codes are 2'b00 startup, 2'b01 standby, 2'b10 normal and 2'b11 reserved. The first strobe comes 500 clocks after reset is released.
- R3: Unlocked, with `mode_i` = 2'b10 and `fb_high_i` high, strobes are 166 clocks apart (60 kHz).
- R4: A change of `mode_i` or `fb_high_i` alters the interval only at a strobe. The interval already in progress completes at its old length.
- R5: Only a rising edge of `sync_i` counts: a low sample followed by a high sample on consecutive clock edges. The width of the high level and the falling edge have no effect. A high level present when reset is released is not an edge.
- R6: The period is the number of clocks between two consecutive counted rising edges. It is valid when it lies from 76 to 333 inclusive (130 kHz to 30 kHz). `period_o` holds the latest valid period, and an invalid period leaves it unchanged.
- R7: `locked_o` rises on the clock edge that measures the second of two consecutive valid periods. An out-of-window period clears the run and drops `locked_o` on that clock edge.
- R8: If no rising edge arrives within 334 clocks of the last counted one, `locked_o` falls. The internal rate then restarts from zero, and its first strobe comes one full selected interval after the drop. An out-of-window edge that drops lock restarts the internal rate the same way.
- R9: While locked, each counted rising edge produces exactly one strobe. The strobe comes floor(P/20) clocks after the clock edge that sampled the rise, where P is the period that edge measured. Internal-rate strobes are suppressed while locked.
- R10: Synchronization and locking work in standby mode exactly as in normal mode.
- R11: `cyc_start_o` is never high for two consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | Digitised external synchronization signal |
| mode_i | input | 2 | Operating mode: 00 startup, 01 standby, 10 normal, 11 reserved |
| fb_high_i | input | 1 | Feedback current above the normal-mode threshold |
| cyc_start_o | output | 1 | One-clock start-of-cycle strobe |
| period_o | output | PERIOD_W (9) | Latest valid sync period in clocks |
| locked_o | output | 1 | Following the external sync signal |

## Verification
The assertions rely on `sync_i` already being synchronous to the system clock. They also assume a newly locked train never places its next edge inside the pending one-twentieth delay. That holds because any locking period is at least 76 clocks, while the delay is at most 16. The stimulus keeps each sync high level shorter than the gap to the next rise and holds `sync_i` low through reset. It changes every input away from the active clock edge. It also tests the window limits with gaps of exactly 75, 76, 333 and 50 clocks, so that each boundary decision is exercised without ambiguity.

// File: rtl/swclk_pkg.sv
package swclk_pkg;

    typedef enum logic [1:0] {
        MODE_START = 2'b00,
        MODE_STBY  = 2'b01,
        MODE_NORM  = 2'b10,
        MODE_RSVD  = 2'b11
    } mode_e;

    // Whole system-clock cycles in one period of the given frequency.
    function automatic int unsigned cycles_for(input int unsigned clk_hz,
                                               input int unsigned hz);
        return clk_hz / hz;
    endfunction

endpackage

// File: rtl/swclk_edge.sv
module swclk_edge (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sync_i,
    output logic rise_o
);

    typedef struct packed {
        logic prev;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = sync_i;
        rise_o    = sync_i & ~st_q.prev;
    end

    // The previous sample starts high, so a level held through reset is no edge.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{prev: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    AST_RISE_FROM_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise_o |-> !$past(sync_i)); // R5

endmodule

// File: rtl/swclk_period.sv
module swclk_period #(
    parameter int unsigned MIN_P = 76,
    parameter int unsigned MAX_P = 333,
    parameter int unsigned PW    = 9
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          rise_i,
    output logic [PW-1:0] meas_o,
    output logic          take_o,
    output logic          locked_o,
    output logic [PW-1:0] period_o
);

    localparam logic [PW-1:0] MIN_V = PW'(MIN_P);
    localparam logic [PW-1:0] MAX_V = PW'(MAX_P);

    typedef struct packed {
        logic [PW-1:0] pcnt;
        logic [1:0]    good;
        logic          locked;
        logic [PW-1:0] period;
    } per_st_t;

    per_st_t st_d, st_q;
    logic    in_window;

    always_comb begin
        st_d      = st_q;
        take_o    = 1'b0;
        meas_o    = st_q.pcnt + PW'(1);
        in_window = (meas_o >= MIN_V) && (meas_o <= MAX_V);

        // Saturating age counter since the last rising edge.
        if (st_q.pcnt == MAX_V) begin
            st_d.pcnt = MAX_V;
        end else begin
            st_d.pcnt = st_q.pcnt + PW'(1);
        end

        if (rise_i) begin
            st_d.pcnt = '0;
            if (in_window) begin
                st_d.period = meas_o;
                if (st_q.good != 2'd2) begin
                    st_d.good = st_q.good + 2'd1;
                end
                if (st_q.good != 2'd0) begin
                    st_d.locked = 1'b1;
                    take_o      = 1'b1;
                end
            end else begin
                st_d.good   = 2'd0;
                st_d.locked = 1'b0;
            end
        end else if (st_q.pcnt == MAX_V) begin
            st_d.good   = 2'd0;
            st_d.locked = 1'b0;
        end
    end

    // The age counter starts saturated: the first edge measures an invalid period.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{pcnt: MAX_V, good: 2'd0, locked: 1'b0, period: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign locked_o = st_q.locked;
    assign period_o = st_q.period;

    AST_LOCK_ON_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(locked_o) |-> $past(rise_i)); // R7

    AST_TIMEOUT_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (locked_o && (st_q.pcnt == MAX_V) && !rise_i) |=> !locked_o); // R8

    AST_PERIOD_IN_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (period_o != '0) |-> ((period_o >= MIN_V) && (period_o <= MAX_V))); // R6

endmodule

// File: rtl/swclk_div.sv
module swclk_div #(
    parameter int unsigned PW    = 9,
    parameter int unsigned DIV   = 20,
    parameter int unsigned SHIFT = 16
) (
    input  logic [PW-1:0] p_i,
    output logic [PW-1:0] q_o
);

    // Rounded-up reciprocal: exact floor for operands far below 2**SHIFT / DIV.
    localparam int unsigned RB     = SHIFT + 2;
    localparam int unsigned PROD_W = PW + RB;
    localparam logic [RB-1:0] RECIP_V = RB'(((64'd1 << SHIFT) + 64'(DIV) - 64'd1) / 64'(DIV));

    logic [PROD_W-1:0] part [RB+1];

    assign part[0] = '0;

    for (genvar gi = 0; gi < RB; gi++) begin : g_term
        if (RECIP_V[gi]) begin : g_add
            assign part[gi+1] = part[gi] + (PROD_W'(p_i) << gi);
        end else begin : g_pass
            assign part[gi+1] = part[gi];
        end
    end

    assign q_o = PW'(part[RB] >> SHIFT);

endmodule

// File: rtl/swclk_freerun.sv
module swclk_freerun #(
    parameter int unsigned SLOW_CNT = 500,
    parameter int unsigned FAST_CNT = 166,
    parameter int unsigned CW       = 9
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    input  logic fast_i,
    output logic fire_o
);

    localparam logic [CW-1:0] SLOW_V = CW'(SLOW_CNT);
    localparam logic [CW-1:0] FAST_V = CW'(FAST_CNT);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [CW-1:0] lim;
    } fr_st_t;

    fr_st_t        st_d, st_q;
    logic [CW-1:0] sel_lim;

    always_comb begin
        st_d    = st_q;
        sel_lim = fast_i ? FAST_V : SLOW_V;
        fire_o  = run_i && (st_q.cnt == st_q.lim - CW'(1));

        if (!run_i || fire_o) begin
            // A new interval length is only picked up at a cycle boundary.
            st_d.cnt = '0;
            st_d.lim = sel_lim;
        end else begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{cnt: '0, lim: SLOW_V};
        end else begin
            st_q <= st_d;
        end
    end

    AST_LIM_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && !fire_o) |=> $stable(st_q.lim)); // R4

    AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.cnt < st_q.lim); // R2

endmodule

// File: rtl/swclk_gen.sv
module swclk_gen
    import swclk_pkg::*;
#(
    parameter int unsigned CLK_HZ     = 10_000_000,
    parameter int unsigned SLOW_HZ    = 20_000,
    parameter int unsigned FAST_HZ    = 60_000,
    parameter int unsigned SYNC_LO_HZ = 30_000,
    parameter int unsigned SYNC_HI_HZ = 130_000,
    parameter int unsigned DLY_DIV    = 20,
    parameter int unsigned PERIOD_W   = $clog2(CLK_HZ / SYNC_LO_HZ + 2)
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                sync_i,
    input  logic [1:0]          mode_i,
    input  logic                fb_high_i,
    output logic                cyc_start_o,
    output logic [PERIOD_W-1:0] period_o,
    output logic                locked_o
);

    localparam int unsigned SLOW_CNT = cycles_for(CLK_HZ, SLOW_HZ);
    localparam int unsigned FAST_CNT = cycles_for(CLK_HZ, FAST_HZ);
    localparam int unsigned MIN_P    = cycles_for(CLK_HZ, SYNC_HI_HZ);
    localparam int unsigned MAX_P    = cycles_for(CLK_HZ, SYNC_LO_HZ);
    localparam int unsigned BIG_CNT  = (SLOW_CNT > FAST_CNT) ? SLOW_CNT : FAST_CNT;
    localparam int unsigned CNT_W    = $clog2(BIG_CNT + 1);

    typedef struct packed {
        logic                arm;
        logic [PERIOD_W-1:0] dly;
        logic                strb;
    } seq_st_t;

    seq_st_t             seq_d, seq_q;
    logic                rise;
    logic                take;
    logic [PERIOD_W-1:0] meas;
    logic [PERIOD_W-1:0] dly_calc;
    logic                free_fire;
    logic                sync_fire;
    logic                fast_sel;

    assign fast_sel = (mode_i == MODE_NORM) && fb_high_i;

    swclk_edge u_edge (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .sync_i (sync_i),
        .rise_o (rise)
    );

    swclk_period #(
        .MIN_P (MIN_P),
        .MAX_P (MAX_P),
        .PW    (PERIOD_W)
    ) u_period (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .rise_i   (rise),
        .meas_o   (meas),
        .take_o   (take),
        .locked_o (locked_o),
        .period_o (period_o)
    );

    swclk_div #(
        .PW  (PERIOD_W),
        .DIV (DLY_DIV)
    ) u_div (
        .p_i (meas),
        .q_o (dly_calc)
    );

    swclk_freerun #(
        .SLOW_CNT (SLOW_CNT),
        .FAST_CNT (FAST_CNT),
        .CW       (CNT_W)
    ) u_freerun (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (!locked_o),
        .fast_i (fast_sel),
        .fire_o (free_fire)
    );

    always_comb begin
        seq_d     = seq_q;
        sync_fire = 1'b0;

        if (take) begin
            // One cycle is spent in the strobe register itself.
            seq_d.arm = 1'b1;
            seq_d.dly = dly_calc - PERIOD_W'(1);
        end else if (rise) begin
            seq_d.arm = 1'b0;
        end else if (seq_q.arm) begin
            if (seq_q.dly == '0) begin
                sync_fire = 1'b1;
                seq_d.arm = 1'b0;
            end else begin
                seq_d.dly = seq_q.dly - PERIOD_W'(1);
            end
        end

        seq_d.strb = sync_fire | free_fire;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seq_q <= '{arm: 1'b0, dly: '0, strb: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign cyc_start_o = seq_q.strb;

    AST_STROBE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cyc_start_o |=> !cyc_start_o); // R11

    AST_FREE_QUIET_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        locked_o |-> !free_fire); // R9

    AST_ARM_NEEDS_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        seq_q.arm |-> locked_o); // R9

    AST_TAKE_DELAY_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        take |-> (dly_calc >= PERIOD_W'(2))); // R9

endmodule

// File: tb/tb_swclk_gen.sv
module tb_swclk_gen;

    localparam int CLK_PERIOD = 10;
    localparam int PW         = 9;

    logic          clk    = 1'b0;
    logic          rst_n  = 1'b0;
    logic          sync_s = 1'b0;
    logic          fb     = 1'b0;
    logic [1:0]    mode   = 2'b00;
    logic          strobe;
    logic [PW-1:0] per;
    logic          lk;

    int    cyc     = 0;
    int    n_chk   = 0;
    int    n_fail  = 0;
    int    exp_cyc[$];
    string exp_req[$];
    bit    mon_en   = 1'b0;
    bit    prev_str = 1'b0;
    bit    done     = 1'b0;

    swclk_gen dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .sync_i      (sync_s),
        .mode_i      (mode),
        .fb_high_i   (fb),
        .cyc_start_o (strobe),
        .period_o    (per),
        .locked_o    (lk)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: every strobe is matched against the next expected cycle.
    always @(negedge clk) begin
        if (mon_en) begin
            if (prev_str) begin
                n_chk++;
                if (strobe) begin
                    n_fail++;
                    $display("FAIL R11: strobe high again at cycle %0d, actual 1 expected 0", cyc);
                end
            end
            if (strobe) begin
                n_chk++;
                if (exp_cyc.size() == 0) begin
                    n_fail++;
                    $display("FAIL R9: unexpected strobe at cycle %0d, expected none", cyc);
                end else begin
                    int    e;
                    string r;
                    e = exp_cyc.pop_front();
                    r = exp_req.pop_front();
                    if (e != cyc) begin
                        n_fail++;
                        $display("FAIL %s: strobe at cycle %0d, expected %0d", r, cyc, e);
                    end
                end
            end
            prev_str = strobe;
        end
    end

    task automatic push(input int c, input string rq);
        exp_cyc.push_back(c);
        exp_req.push_back(rq);
    endtask

    task automatic check_eq(input string rq, input string what, input int act, input int expv);
        n_chk++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s: %s actual %0d expected %0d", rq, what, act, expv);
        end
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic drain(input string rq);
        n_chk++;
        if (exp_cyc.size() != 0) begin
            n_fail++;
            $display("FAIL %s: missing strobe, actual none expected at cycle %0d", rq, exp_cyc[0]);
        end
        exp_cyc.delete();
        exp_req.delete();
    endtask

    task automatic do_reset(output int r);
        mon_en = 1'b0;
        rst_n  = 1'b0;
        sync_s = 1'b0;
        exp_cyc.delete();
        exp_req.delete();
        repeat (3) @(negedge clk);
        check_eq("R1", "strobe in reset", int'(strobe), 0);
        check_eq("R1", "locked in reset", int'(lk), 0);
        check_eq("R1", "period in reset", int'(per), 0);
        rst_n    = 1'b1;
        r        = cyc;
        prev_str = 1'b0;
        mon_en   = 1'b1;
    endtask

    task automatic sync_pulse(input int rise, input int width);
        wait_until(rise);
        sync_s = 1'b1;
        repeat (width) @(negedge clk);
        sync_s = 1'b0;
    endtask

    initial begin
        int r;
        int c0;
        int cl;
        int e1, e2, e3, e4, e5, e6;
        @(negedge clk);

        // Phase 1: internal rates and boundary-only rate changes (R2, R3, R4)
        mode = 2'b00;
        fb   = 1'b0;
        do_reset(r);
        push(r + 500,  "R2");
        push(r + 1000, "R2");
        push(r + 1500, "R2");
        wait_until(r + 600);
        mode = 2'b01;
        push(r + 2000, "R4");
        push(r + 2166, "R3");
        push(r + 2332, "R3");
        push(r + 2498, "R3");
        wait_until(r + 1600);
        mode = 2'b10;
        fb   = 1'b1;
        wait_until(r + 2550);
        fb   = 1'b0;
        push(r + 2664, "R4");
        push(r + 3164, "R2");
        wait_until(r + 3200);
        drain("R4");

        // Phase 2: lock in normal mode, delay, duty independence, timeout (R5-R9)
        mode = 2'b10;
        fb   = 1'b0;
        do_reset(r);
        c0 = r + 520;
        cl = c0 + 1400;
        push(r + 500, "R2");
        for (int k = 2; k < 8; k++) push(c0 + 200 * k + 11, "R9");
        push(cl + 835, "R8");
        for (int k = 0; k < 8; k++) begin
            sync_pulse(c0 + 200 * k, (k % 2 == 1) ? 150 : 30);
            if (k == 1) begin
                check_eq("R6", "period after first gap", int'(per), 200);
                check_eq("R7", "locked after one valid period", int'(lk), 0);
            end
            if (k == 2) check_eq("R7", "locked after two valid periods", int'(lk), 1);
        end
        check_eq("R5", "period with wide high levels", int'(per), 200);
        wait_until(cl + 334);
        check_eq("R8", "locked just before timeout", int'(lk), 1);
        @(negedge clk);
        check_eq("R8", "locked after timeout", int'(lk), 0);
        check_eq("R6", "period kept after timeout", int'(per), 200);
        wait_until(cl + 900);
        drain("R8");

        // Phase 3: window limits, run clearing, standby lock (R6, R7, R10)
        mode = 2'b01;
        fb   = 1'b0;
        do_reset(r);
        c0 = r + 510;
        e1 = c0 + 76;
        e2 = e1 + 75;
        e3 = e2 + 76;
        e4 = e3 + 76;
        e5 = e4 + 333;
        e6 = e5 + 50;
        push(r + 500, "R2");
        push(e4 + 4,  "R10");
        push(e5 + 17, "R9");
        push(e6 + 501, "R7");
        sync_pulse(c0, 20);
        sync_pulse(e1, 20);
        check_eq("R6", "period at lower bound 76", int'(per), 76);
        sync_pulse(e2, 20);
        check_eq("R6", "period kept after gap 75", int'(per), 76);
        sync_pulse(e3, 20);
        check_eq("R7", "locked after cleared run", int'(lk), 0);
        sync_pulse(e4, 20);
        check_eq("R10", "locked in standby", int'(lk), 1);
        sync_pulse(e5, 20);
        check_eq("R6", "period at upper bound 333", int'(per), 333);
        sync_pulse(e6, 20);
        check_eq("R7", "locked after gap 50", int'(lk), 0);
        check_eq("R6", "period kept after gap 50", int'(per), 333);
        wait_until(e6 + 560);
        drain("R7");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual cycle %0d expected below 200000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule